// File: doc/BRIEF.md
# Command Write Buffer Arbiter

This block sits between a byte-level management-bus transaction front end and a slower internal command executor. Every supported command code owns a single data slot. A bus write stores its byte in that slot and marks the code as pending. A later write to the same code overwrites the slot, so only the most recent value is ever handed on. The executor works on its own schedule. It always sees the lowest-numbered pending code together with that code's data, and it retires the code with a one-cycle acknowledge. Commands can therefore be executed in an order different from the order in which they arrived.

The block is busy while any code is pending or while the executor reports work in progress. An idle flag, also readable as bit 5 of a status code, tells the host when it may send the next command. The status code can be read at any time and is never refused. Any other transaction that arrives while the block is busy is answered according to four independent configuration bits: a NACK, an all-ones read override, a sticky busy fault with ALERT, and an SCL hold. The SCL hold applies only on a fast bus (above 100 kHz).

Top module: `cmd_wbuf_arbiter`

## Requirements
- R1: A read of a supported code (0 to NCMD-1) returns, in the same cycle, the last byte accepted for that code, unless the all-ones override applies.
- R2: An accepted write to a supported code makes `ex_valid` high from the next cycle.
- R3: Two writes to the same code before it is fetched leave one pending entry, and the executor sees the data of the second write.
- R4: `ex_code`/`ex_data` show the lowest-numbered pending code and its slot. `ex_ack` while `ex_valid` retires that code from the next cycle.
- R5: If `ex_ack` and an accepted write to the presented code fall in the same cycle, the code stays pending and carries the new data.
- R6: `calc_idle` is 0 while any code is pending or `ex_busy` is high. A read of status code 15 returns `calc_idle` in bit 5 (other bits 0), is never NACKed and is never overridden.
- R7: With `cfg_nack` set, a non-status transaction during busy raises `bus_nack` in the same cycle. A NACKed write is discarded.
- R8: With `cfg_ones` set, a non-status read during busy returns 0xFF and raises `bus_rd_ovr` in the same cycle.
- R9: With `cfg_fault` set, a non-status transaction during busy sets `busy_fault` and `alert` from the next cycle. Both stay set until a cycle with `fault_clr`, which clears them from the next cycle and takes precedence over a new set.
- R10: `scl_hold` rises the cycle after a non-status transaction during busy, and only when both `cfg_stretch` and `fast_mode` are set. It falls the cycle after busy ends.
- R11: After reset nothing is pending, `calc_idle` is 1, and `busy_fault`, `alert` and `scl_hold` are 0. A transaction while idle draws no busy response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cmd | input | CW | Decoded command code of the current transaction |
| bus_wdata | input | DW | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_nack | output | 1 | Refuse the current transaction |
| bus_rdata | output | DW | Read data for the current request |
| bus_rd_ovr | output | 1 | Read data forced to all ones because busy |
| cfg_nack | input | 1 | Busy policy: NACK |
| cfg_ones | input | 1 | Busy policy: all-ones reads |
| cfg_fault | input | 1 | Busy policy: fault and ALERT |
| cfg_stretch | input | 1 | Busy policy: SCL hold enable |
| fast_mode | input | 1 | Bus clock above 100 kHz |
| fault_clr | input | 1 | Clear busy fault and ALERT |
| busy_fault | output | 1 | Sticky busy fault flag |
| alert | output | 1 | ALERT request |
| scl_hold | output | 1 | Hold SCL low |
| ex_valid | output | 1 | A command is pending for the executor |
| ex_code | output | IW | Lowest pending command code |
| ex_data | output | DW | Buffered data of `ex_code` |
| ex_ack | input | 1 | Executor has fetched `ex_code` |
| ex_busy | input | 1 | Executor is still processing |
| calc_idle | output | 1 | No calculation pending |

## Verification
The bus responses (`bus_nack`, `bus_rdata`, `bus_rd_ovr`) are combinational. They are sampled one time unit after the inputs change at the falling edge, before the rising edge that accepts the transaction. Pending state, `busy_fault`, `alert` and `scl_hold` are single registers, so they are checked at the falling edge after the accepting rising edge. The executor port is read the same way, one cycle after a write or acknowledge. Each scenario task drives its stimulus and then samples each output at the cycle where it is due.

// File: rtl/cmd_wbuf_arbiter.sv
module cmd_wbuf_arbiter #(
  parameter int NCMD      = 8,
  parameter int CW        = 4,
  parameter int DW        = 8,
  parameter int STAT_CODE = 15,
  parameter int RDY_BIT   = 5,
  localparam int IW       = $clog2(NCMD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] bus_cmd,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic          bus_nack,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rd_ovr,
  input  logic          cfg_nack,
  input  logic          cfg_ones,
  input  logic          cfg_fault,
  input  logic          cfg_stretch,
  input  logic          fast_mode,
  input  logic          fault_clr,
  output logic          busy_fault,
  output logic          alert,
  output logic          scl_hold,
  output logic          ex_valid,
  output logic [IW-1:0] ex_code,
  output logic [DW-1:0] ex_data,
  input  logic          ex_ack,
  input  logic          ex_busy,
  output logic          calc_idle
);
  localparam logic [CW-1:0] SC = CW'(STAT_CODE);
  localparam logic [CW-1:0] NC = CW'(NCMD);

  logic [DW-1:0]   slot [NCMD];
  logic [NCMD-1:0] pend;
  logic            busy, is_stat, in_rng, txn, busy_hit, wr_acc, fetch;
  logic [DW-1:0]   stat;

  assign busy     = (|pend) | ex_busy;
  assign is_stat  = bus_cmd == SC;
  assign in_rng   = bus_cmd < NC;
  assign txn      = (bus_wr | bus_rd) & ~is_stat;
  assign busy_hit = txn & busy;
  assign bus_nack = busy_hit & cfg_nack;
  assign wr_acc   = bus_wr & in_rng & ~bus_nack;
  assign bus_rd_ovr = bus_rd & busy_hit & cfg_ones;
  assign ex_valid = |pend;
  assign ex_data  = slot[ex_code];
  assign fetch    = ex_ack & ex_valid;
  assign calc_idle = ~busy;
  assign alert    = busy_fault;

  always_comb begin
    stat = '0;
    stat[RDY_BIT] = ~busy;
  end

  always_comb begin
    ex_code = '0;
    for (int i = NCMD - 1; i >= 0; i--)
      if (pend[i]) ex_code = IW'(i);
  end

  always_comb begin
    if (is_stat)         bus_rdata = stat;
    else if (bus_rd_ovr) bus_rdata = '1;
    else if (in_rng)     bus_rdata = slot[bus_cmd[IW-1:0]];
    else                 bus_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NCMD; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < NCMD; i++) begin
        if (wr_acc && bus_cmd == CW'(i)) begin
          slot[i] <= bus_wdata;
          pend[i] <= 1'b1;
        end else if (fetch && ex_code == IW'(i)) begin
          pend[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     busy_fault <= 1'b0;
    else if (fault_clr)             busy_fault <= 1'b0;
    else if (busy_hit && cfg_fault) busy_fault <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        scl_hold <= 1'b0;
    else if (scl_hold) scl_hold <= busy;
    else               scl_hold <= busy_hit & cfg_stretch & fast_mode;
  end
endmodule

// File: rtl/cmd_wbuf_arbiter_chk.sv
module cmd_wbuf_arbiter_chk #(
  parameter int NCMD = 8, parameter int CW = 4, parameter int DW = 8,
  parameter int STAT_CODE = 15, parameter int RDY_BIT = 5,
  parameter int IW = 3
) (
  input logic clk, rst_n,
  input logic [CW-1:0] bus_cmd,
  input logic bus_wr, bus_rd, bus_nack, bus_rd_ovr,
  input logic [DW-1:0] bus_rdata,
  input logic cfg_nack, cfg_fault, cfg_stretch, fast_mode, fault_clr,
  input logic busy_fault, scl_hold, ex_valid, ex_ack, calc_idle,
  input logic [IW-1:0] ex_code
);
  localparam logic [CW-1:0] SC = CW'(STAT_CODE);
  localparam logic [CW-1:0] NC = CW'(NCMD);

  a_r2_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_nack && bus_cmd < NC) |=> (ex_valid && CW'(ex_code) <= $past(bus_cmd)));

  a_r4_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ack && !(bus_wr && bus_cmd == CW'(ex_code)))
      |=> (!ex_valid || ex_code != $past(ex_code)));

  a_r6_status_served: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_cmd == SC) |-> (!bus_nack && !bus_rd_ovr && bus_rdata[RDY_BIT] == calc_idle));

  a_r7_nack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nack |-> (!calc_idle && cfg_nack));

  a_r8_override_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_ovr |-> (bus_rdata == '1 && !calc_idle));

  a_r9_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!calc_idle && cfg_fault && (bus_wr || bus_rd) && bus_cmd != SC && !fault_clr) |=> busy_fault);

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_fault && !fault_clr) |=> busy_fault);

  a_r10_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(cfg_stretch && fast_mode && !calc_idle));

  a_r10_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && calc_idle) |=> !scl_hold);
endmodule

bind cmd_wbuf_arbiter cmd_wbuf_arbiter_chk #(
  .NCMD(NCMD), .CW(CW), .DW(DW), .STAT_CODE(STAT_CODE), .RDY_BIT(RDY_BIT), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_nack(bus_nack), .bus_rd_ovr(bus_rd_ovr), .bus_rdata(bus_rdata),
  .cfg_nack(cfg_nack), .cfg_fault(cfg_fault), .cfg_stretch(cfg_stretch),
  .fast_mode(fast_mode), .fault_clr(fault_clr), .busy_fault(busy_fault),
  .scl_hold(scl_hold), .ex_valid(ex_valid), .ex_ack(ex_ack),
  .calc_idle(calc_idle), .ex_code(ex_code)
);

// File: tb/cmd_wbuf_arbiter_bench.sv
module cmd_wbuf_arbiter_bench;
  localparam int PERIOD = 10;
  localparam int CW = 4, DW = 8, IW = 3;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] bus_cmd = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0, ex_ack = 0, ex_busy = 0;
  logic cfg_nack = 0, cfg_ones = 0, cfg_fault = 0, cfg_stretch = 0, fast_mode = 0, fault_clr = 0;
  logic bus_nack, bus_rd_ovr, busy_fault, alert, scl_hold, ex_valid, calc_idle;
  logic [DW-1:0] bus_rdata, ex_data;
  logic [IW-1:0] ex_code;

  int checks = 0, fails = 0;
  logic s_nack, s_ovr;
  logic [DW-1:0] s_rd;

  always #(PERIOD/2) clk = ~clk;

  cmd_wbuf_arbiter u_cmd_wbuf_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_nack(bus_nack), .bus_rdata(bus_rdata),
    .bus_rd_ovr(bus_rd_ovr), .cfg_nack(cfg_nack), .cfg_ones(cfg_ones),
    .cfg_fault(cfg_fault), .cfg_stretch(cfg_stretch), .fast_mode(fast_mode),
    .fault_clr(fault_clr), .busy_fault(busy_fault), .alert(alert),
    .scl_hold(scl_hold), .ex_valid(ex_valid), .ex_code(ex_code), .ex_data(ex_data),
    .ex_ack(ex_ack), .ex_busy(ex_busy), .calc_idle(calc_idle)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xact(logic wr, logic rd, logic [CW-1:0] code, logic [DW-1:0] d, logic ack);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_cmd = code; bus_wdata = d; ex_ack = ack;
    #1;
    s_nack = bus_nack; s_ovr = bus_rd_ovr; s_rd = bus_rdata;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ex_ack = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 ex_valid", ex_valid, 0);
    chk("R11 calc_idle", calc_idle, 1);
    chk("R11 fault", busy_fault, 0);
    chk("R11 alert", alert, 0);
    chk("R11 hold", scl_hold, 0);
    xact(0, 1, 4'd15, 0, 0);
    chk("R6 status idle", s_rd, 8'h20);
  endtask

  task automatic t_overwrite();
    xact(1, 0, 4'd3, 8'h11, 0);
    chk("R2 pending", ex_valid, 1);
    xact(1, 0, 4'd3, 8'h22, 0);
    chk("R3 code", ex_code, 3);
    chk("R3 latest data", ex_data, 8'h22);
    chk("R6 idle low", calc_idle, 0);
    xact(0, 1, 4'd15, 0, 0);
    chk("R6 status busy", s_rd, 8'h00);
    chk("R6 status no nack", s_nack, 0);
    xact(0, 1, 4'd3, 0, 0);
    chk("R1 readback", s_rd, 8'h22);
    xact(0, 0, 0, 0, 1);
    chk("R3 single entry", ex_valid, 0);
    chk("R6 idle again", calc_idle, 1);
  endtask

  task automatic t_order();
    xact(1, 0, 4'd5, 8'hA5, 0);
    xact(1, 0, 4'd2, 8'hB2, 0);
    chk("R4 lowest code", ex_code, 2);
    chk("R4 lowest data", ex_data, 8'hB2);
    xact(0, 0, 0, 0, 1);
    chk("R4 next code", ex_code, 5);
    chk("R4 next data", ex_data, 8'hA5);
    xact(0, 0, 0, 0, 1);
    chk("R4 drained", ex_valid, 0);
  endtask

  task automatic t_collide();
    xact(1, 0, 4'd4, 8'h40, 0);
    xact(1, 0, 4'd4, 8'h44, 1);
    chk("R5 still pending", ex_valid, 1);
    chk("R5 new data", ex_data, 8'h44);
    xact(0, 0, 0, 0, 1);
    chk("R5 drained", ex_valid, 0);
  endtask

  task automatic t_nack();
    cfg_nack = 1;
    xact(1, 0, 4'd6, 8'h06, 0);
    chk("R11 idle no nack", s_nack, 0);
    xact(0, 0, 0, 0, 1);
    ex_busy = 1;
    xact(1, 0, 4'd6, 8'h66, 0);
    chk("R7 write nack", s_nack, 1);
    chk("R7 write discarded", ex_valid, 0);
    xact(0, 1, 4'd6, 0, 0);
    chk("R7 read nack", s_nack, 1);
    xact(0, 1, 4'd15, 0, 0);
    chk("R6 status not nacked", s_nack, 0);
    ex_busy = 0;
    xact(0, 1, 4'd6, 0, 0);
    chk("R7 discarded data", s_rd, 8'h06);
    cfg_nack = 0;
  endtask

  task automatic t_ones();
    cfg_ones = 1; ex_busy = 1;
    xact(0, 1, 4'd3, 0, 0);
    chk("R8 ones", s_rd, 8'hFF);
    chk("R8 ovr flag", s_ovr, 1);
    xact(0, 1, 4'd15, 0, 0);
    chk("R6 status not ovr", s_ovr, 0);
    ex_busy = 0;
    xact(0, 1, 4'd3, 0, 0);
    chk("R1 idle read", s_rd, 8'h22);
    chk("R8 no ovr idle", s_ovr, 0);
    cfg_ones = 0;
  endtask

  task automatic t_fault();
    cfg_fault = 1;
    xact(0, 1, 4'd1, 0, 0);
    chk("R11 idle no fault", busy_fault, 0);
    ex_busy = 1;
    xact(0, 1, 4'd1, 0, 0);
    chk("R9 fault set", busy_fault, 1);
    chk("R9 alert set", alert, 1);
    ex_busy = 0;
    repeat (3) @(negedge clk);
    chk("R9 sticky", busy_fault, 1);
    @(negedge clk); fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    chk("R9 cleared", busy_fault, 0);
    chk("R9 alert cleared", alert, 0);
    cfg_fault = 0;
  endtask

  task automatic t_stretch();
    cfg_stretch = 1; fast_mode = 0; ex_busy = 1;
    xact(0, 1, 4'd2, 0, 0);
    chk("R10 slow no hold", scl_hold, 0);
    fast_mode = 1;
    xact(0, 1, 4'd2, 0, 0);
    chk("R10 fast hold", scl_hold, 1);
    repeat (3) @(negedge clk);
    chk("R10 hold while busy", scl_hold, 1);
    ex_busy = 0;
    @(negedge clk);
    chk("R10 release", scl_hold, 0);
    cfg_stretch = 0; ex_busy = 1;
    xact(0, 1, 4'd2, 0, 0);
    chk("R10 disabled no hold", scl_hold, 0);
    ex_busy = 0; fast_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_overwrite();
    t_order();
    t_collide();
    t_nack();
    t_ones();
    t_fault();
    t_stretch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule